// File: doc/BRIEF.md
# Counting Response Compactor

This block turns the single-bit serial response of a circuit under test into a short count signature for built-in self test. A two-bit mode selects the signature: the number of ones in the response, the number of changes between consecutive response bits, or a syndrome pair. The syndrome pair is the ones count together with the number of applied patterns. Software or a test controller forms the ratio from these two numbers. For exhaustive testing of an n-input function, the pattern count reaches 2^n and the ones count equals the number of minterms.

A start pulse clears the run and latches the mode. Each cycle with the valid strobe high contributes one response bit. An end-of-test strobe compares the signature against a golden count. One cycle later it raises a done pulse and a held pass flag. A circuit with several outputs uses one instance per output. It can also reuse a single instance once per output while the same stimulus is replayed.

Top module: `resp_count_compactor`

## Requirements
- R1: While `rst` is high, and in the cycle after a `start` pulse, `sig_count`, `pat_count`, `done` and `pass` are all zero, and the previous-bit state is cleared.
- R2: In mode code 0 (ones) and code 3 (treated as ones), `sig_count` rises by one for every valid response bit equal to 1.
- R3: In mode code 1 (transitions), `sig_count` rises by one for every valid bit that differs from the previous valid bit of the same run. Both 0-to-1 and 1-to-0 changes count. The first valid bit after `start` only loads the previous-bit state, so N bits give at most N-1.
- R4: In mode code 2 (syndrome), `sig_count` holds the ones count and `pat_count` holds the number of applied patterns.
- R5: In every mode, `pat_count` rises by one for each valid bit and saturates at its all-ones value.
- R6: `mode_sel` is sampled only in a `start` cycle. Changing it during a run has no effect on counting.
- R7: An `end_test` strobe gives `done` high for exactly the next cycle. In that same cycle, `pass` = 1 only if the count equals `golden`. That count includes a valid bit presented in the `end_test` cycle itself. `pass` holds until the next `start` or reset.
- R8: `start` has priority. A response bit or `end_test` presented in the `start` cycle is discarded.
- R9: `sig_count` saturates at its all-ones value instead of wrapping. Its width holds `MAX_LEN` without wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run: clear counts, latch mode |
| mode_sel | input | 2 | 0 ones, 1 transitions, 2 syndrome, 3 ones |
| resp_vld | input | 1 | Response bit is valid this cycle |
| resp_bit | input | 1 | Serial response bit |
| end_test | input | 1 | Finish run and compare |
| golden | input | CW | Expected signature count |
| sig_count | output | CW | Running signature count |
| pat_count | output | CW | Number of applied patterns |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Signature matched golden |

## Verification
The two functions that can coincide are the last response bit and the end-of-test compare. The bench provokes this by raising `end_test` in the same cycle as a final valid bit. It then judges that `pass` reflects the count including that bit, and that `sig_count` shows the same value while `done` is high. A second collision raises `start` together with a valid one-bit. The bench checks that the bit leaves no trace in either count.

// File: rtl/resp_cmp_pkg.sv
package resp_cmp_pkg;
    typedef enum logic [1:0] {
        MODE_ONES  = 2'd0,
        MODE_TRANS = 2'd1,
        MODE_SYND  = 2'd2,
        MODE_ONES2 = 2'd3
    } cmp_mode_e;
endpackage

// File: rtl/resp_sat_inc.sv
module resp_sat_inc #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         en,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = '1;

    always_comb begin
        nxt = val;
        if (en && (val != TOP)) begin
            nxt = val + W'(1);
        end
    end
endmodule

// File: rtl/resp_step_eval.sv
module resp_step_eval
    import resp_cmp_pkg::*;
(
    input  cmp_mode_e mode,
    input  logic      cur_bit,
    input  logic      prev_bit,
    input  logic      prev_ok,
    output logic      hit
);
    always_comb begin
        unique case (mode)
            MODE_TRANS: hit = prev_ok & (cur_bit ^ prev_bit);
            default:    hit = cur_bit;
        endcase
    end
endmodule

// File: rtl/resp_count_compactor.sv
module resp_count_compactor
    import resp_cmp_pkg::*;
#(
    parameter int MAX_LEN = 1024,
    parameter int CW      = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode_sel,
    input  logic          resp_vld,
    input  logic          resp_bit,
    input  logic          end_test,
    input  logic [CW-1:0] golden,
    output logic [CW-1:0] sig_count,
    output logic [CW-1:0] pat_count,
    output logic          done,
    output logic          pass
);
    typedef struct packed {
        logic [CW-1:0] sig;
        logic [CW-1:0] pat;
        logic          prev_bit;
        logic          prev_ok;
        cmp_mode_e     mode;
        logic          done;
        logic          pass;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    logic          step_hit;
    logic [CW-1:0] sig_inc, pat_inc;
    logic [1:0]    run_mode;

    resp_step_eval u_step (
        .mode     (st_q.mode),
        .cur_bit  (resp_bit),
        .prev_bit (st_q.prev_bit),
        .prev_ok  (st_q.prev_ok),
        .hit      (step_hit)
    );

    resp_sat_inc #(.W(CW)) u_sig_inc (
        .val (st_q.sig),
        .en  (resp_vld & step_hit),
        .nxt (sig_inc)
    );

    resp_sat_inc #(.W(CW)) u_pat_inc (
        .val (st_q.pat),
        .en  (resp_vld),
        .nxt (pat_inc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.sig      = '0;
            st_d.pat      = '0;
            st_d.prev_bit = 1'b0;
            st_d.prev_ok  = 1'b0;
            st_d.mode     = cmp_mode_e'(mode_sel);
            st_d.pass     = 1'b0;
        end else begin
            if (resp_vld) begin
                st_d.sig      = sig_inc;
                st_d.pat      = pat_inc;
                st_d.prev_bit = resp_bit;
                st_d.prev_ok  = 1'b1;
            end
            if (end_test) begin
                st_d.done = 1'b1;
                st_d.pass = (st_d.sig == golden);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{sig: '0, pat: '0, prev_bit: 1'b0, prev_ok: 1'b0,
                      mode: MODE_ONES, done: 1'b0, pass: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_mode  = st_q.mode;
    assign sig_count = st_q.sig;
    assign pat_count = st_q.pat;
    assign done      = st_q.done;
    assign pass      = st_q.pass;
endmodule

// File: rtl/resp_count_checker.sv
module resp_count_checker #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          resp_vld,
    input logic          end_test,
    input logic [CW-1:0] golden,
    input logic [CW-1:0] sig_count,
    input logic [CW-1:0] pat_count,
    input logic          done,
    input logic          pass,
    input logic [1:0]    run_mode
);
    localparam logic [CW-1:0] TOP = '1;

    assert_start_clear_R1: assert property (@(posedge clk) disable iff (rst)
        start |=> (sig_count == '0) && (pat_count == '0) && !pass && !done);

    assert_trans_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run_mode == 2'd1) && (pat_count != '0) && (pat_count != TOP) |-> sig_count < pat_count);

    assert_pat_step_R5: assert property (@(posedge clk) disable iff (rst)
        resp_vld && !start && (pat_count != TOP) |=> pat_count == $past(pat_count) + CW'(1));

    assert_pat_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !resp_vld && !start |=> $stable(sig_count) && $stable(pat_count));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        end_test && !start |=> done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !end_test || start |=> !done);

    assert_pass_match_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> pass == (sig_count == $past(golden)));

    assert_pass_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !end_test && !start |=> $stable(pass));

    assert_no_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        !start && (sig_count == TOP) |=> sig_count == TOP);
endmodule

bind resp_count_compactor resp_count_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .resp_vld  (resp_vld),
    .end_test  (end_test),
    .golden    (golden),
    .sig_count (sig_count),
    .pat_count (pat_count),
    .done      (done),
    .pass      (pass),
    .run_mode  (run_mode)
);

// File: tb/resp_count_compactor_bench.sv
module resp_count_compactor_bench;
    localparam int MAX_LEN = 8;
    localparam int CW      = $clog2(MAX_LEN + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic          resp_vld = 1'b0;
    logic          resp_bit = 1'b0;
    logic          end_test = 1'b0;
    logic [CW-1:0] golden = '0;
    logic [CW-1:0] sig_count, pat_count;
    logic          done, pass;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    resp_count_compactor #(.MAX_LEN(MAX_LEN)) u_resp_count_compactor (
        .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
        .resp_vld(resp_vld), .resp_bit(resp_bit), .end_test(end_test),
        .golden(golden), .sig_count(sig_count), .pat_count(pat_count),
        .done(done), .pass(pass)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic begin_run(input logic [1:0] m);
        @(negedge clk);
        start = 1'b1; mode_sel = m;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send_bits(input logic [31:0] bits, input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            resp_vld = 1'b1; resp_bit = bits[i];
        end
        @(negedge clk);
        resp_vld = 1'b0; resp_bit = 1'b0;
    endtask

    task automatic finish_run(input int g, input int exp_pass, input string req);
        @(negedge clk);
        end_test = 1'b1; golden = CW'(g);
        @(negedge clk);
        end_test = 1'b0;
        chk(req, "done pulse", int'(done), 1);
        chk(req, "pass", int'(pass), exp_pass);
        @(negedge clk);
        chk(req, "done low after pulse", int'(done), 0);
        chk(req, "pass held", int'(pass), exp_pass);
    endtask

    task automatic t_reset;
        chk("R1", "sig after reset", int'(sig_count), 0);
        chk("R1", "pat after reset", int'(pat_count), 0);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "pass after reset", int'(pass), 0);
    endtask

    task automatic t_ones;
        begin_run(2'd0);
        chk("R1", "sig cleared by start", int'(sig_count), 0);
        send_bits(32'b0100_1101, 8);
        chk("R2", "ones count", int'(sig_count), 4);
        chk("R5", "pattern count", int'(pat_count), 8);
        finish_run(4, 1, "R7");
    endtask

    task automatic t_trans;
        begin_run(2'd1);
        chk("R1", "pass cleared by start", int'(pass), 0);
        mode_sel = 2'd0;
        send_bits(32'b0001_0110, 8);
        chk("R3", "transition count", int'(sig_count), 4);
        chk("R6", "mode change ignored", int'(sig_count), 4);
        finish_run(5, 0, "R7");
    endtask

    task automatic t_trans_gaps;
        begin_run(2'd1);
        send_bits(32'b1, 1);
        chk("R3", "first bit no transition", int'(sig_count), 0);
        chk("R3", "first bit counted as pattern", int'(pat_count), 1);
        repeat (3) @(negedge clk);
        send_bits(32'b1, 1);
        chk("R3", "same bit after gap", int'(sig_count), 0);
        send_bits(32'b0, 1);
        chk("R3", "1-to-0 after gap", int'(sig_count), 1);
    endtask

    task automatic t_syndrome;
        logic [31:0] and3, or3;
        and3 = '0; or3 = '0;
        for (int i = 0; i < 8; i++) begin
            and3[i] = (i == 7);
            or3[i]  = (i != 0);
        end
        begin_run(2'd2);
        send_bits(and3, 8);
        chk("R4", "AND3 minterms", int'(sig_count), 1);
        chk("R4", "AND3 patterns", int'(pat_count), 8);
        finish_run(1, 1, "R4");
        begin_run(2'd2);
        send_bits(or3, 8);
        chk("R4", "OR3 minterms", int'(sig_count), 7);
        chk("R4", "OR3 patterns", int'(pat_count), 8);
        begin_run(2'd3);
        send_bits(32'b0110, 4);
        chk("R2", "code 3 counts ones", int'(sig_count), 2);
    endtask

    task automatic t_same_cycle;
        begin_run(2'd0);
        send_bits(32'b11, 2);
        @(negedge clk);
        resp_vld = 1'b1; resp_bit = 1'b1; end_test = 1'b1; golden = CW'(3);
        @(negedge clk);
        resp_vld = 1'b0; resp_bit = 1'b0; end_test = 1'b0;
        chk("R7", "final bit counted", int'(sig_count), 3);
        chk("R7", "done with final bit", int'(done), 1);
        chk("R7", "pass includes final bit", int'(pass), 1);
    endtask

    task automatic t_start_collide;
        begin_run(2'd0);
        send_bits(32'b111, 3);
        @(negedge clk);
        start = 1'b1; mode_sel = 2'd0; resp_vld = 1'b1; resp_bit = 1'b1; end_test = 1'b1;
        @(negedge clk);
        start = 1'b0; resp_vld = 1'b0; resp_bit = 1'b0; end_test = 1'b0;
        chk("R8", "bit in start cycle dropped (sig)", int'(sig_count), 0);
        chk("R8", "bit in start cycle dropped (pat)", int'(pat_count), 0);
        chk("R8", "end_test in start cycle dropped", int'(done), 0);
    endtask

    task automatic t_saturate;
        begin_run(2'd0);
        send_bits(32'h1_FFFF, 17);
        chk("R9", "sig saturates", int'(sig_count), 15);
        chk("R5", "pat saturates", int'(pat_count), 15);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ones();
        t_trans();
        t_trans_gaps();
        t_syndrome();
        t_same_cycle();
        t_start_collide();
        t_saturate();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #50000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule